// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write an external static RAM that has no clock of its own. The memory sees an 18-bit address, a 4-bit data bus shared by both directions, and three active-low strobes: select, write and output enable. The host gives one request at a time through a valid/ready handshake carrying an address, a write flag and write data. Reads come back as data with a one-cycle valid pulse.

Every access is a fixed sequence of phases. Each phase lasts a parameterised number of clock cycles, so the memory's minimum pulse, setup and access times are met at the chosen clock. The shared bus is split into an output value, a driver enable and an input value, and the board or pad ring joins them. The controller orders the bus turnaround so that it never drives while the memory might still drive.

A build parameter picks how writes handle output enable. Output enable can be held high for the whole write, which allows the short write pulse. It can also be left low, which calls for the longer pulse the memory needs in that case.

Top module: `sac_async_sram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, select, write and output enable are all high, the data driver is off, ready is high and the response valid is low.
- R2: A request is taken only in a cycle where ready and valid are both high. Ready goes low in the cycle after acceptance and stays low until the access has finished.
- R3: A read drives select low with output enable high for SETUP_CYC cycles, then holds output enable low for RD_CYC cycles. Write enable stays high and the driver stays off throughout.
- R4: Read data is sampled from the bus in the last cycle with output enable low. The response valid is high for exactly one cycle, SETUP_CYC+RD_CYC+1 negative clock edges after the request was presented, and it carries that data.
- R5: A write holds select low for SETUP_CYC cycles with write enable high, then drives write enable low for TURN_CYC+WP cycles. The data driver is enabled, presenting the write data, only for the last WP of those cycles. WP is WP_OE_HI_CYC when WR_OE_HIGH=1 and WP_OE_LO_CYC when WR_OE_HIGH=0.
- R6: The driver is never on while the memory is in its read state (select low, write enable high, output enable low). It stays on for exactly one cycle after write enable rises and is off in the cycle after that.
- R7: Write enable is low only while select is low, and the memory address does not change while select stays low.
- R8: With WR_OE_HIGH=1, output enable is high in every cycle of a write. With WR_OE_HIGH=0, it is low in every cycle where write enable is low.
- R9: Address and write data are taken at acceptance. Changing the request inputs during an access has no effect on the memory address or the bus data of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Request address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 4 | Read data |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 4 | Value the controller drives on the data bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 4 | Value read from the data bus |

## Verification
The two functions that can land in the same cycle are the bus handover when write enable falls and the start of the controller's own drive. The same applies to the release of that drive and the end of the write. Writes are followed straight away by reads of the same address, on one instance that holds output enable high and on another that leaves it low. The bench memory model reports any cycle where both sides would drive. It also checks cycle by cycle that the driver comes on only after the turnaround and goes off one cycle after write enable rises.

// File: rtl/sac_pkg.sv
package sac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RSETUP = 3'd1,
    ST_RACC   = 3'd2,
    ST_WSETUP = 3'd3,
    ST_WTURN  = 3'd4,
    ST_WPULSE = 3'd5,
    ST_WREL   = 3'd6
  } sac_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } sac_strobe_t;

  // Write pulse length with the data driven, picked by output-enable mode.
  function automatic int unsigned sac_wp_cycles(input bit oe_high,
                                                input int unsigned hi_cyc,
                                                input int unsigned lo_cyc);
    return oe_high ? hi_cyc : lo_cyc;
  endfunction

  // Number of cycles a state lasts once entered.
  function automatic int unsigned sac_phase_cycles(input sac_state_e st,
                                                   input int unsigned setup_cyc,
                                                   input int unsigned rd_cyc,
                                                   input int unsigned turn_cyc,
                                                   input int unsigned wp_cyc);
    case (st)
      ST_RSETUP, ST_WSETUP: return setup_cyc;
      ST_RACC:              return rd_cyc;
      ST_WTURN:             return turn_cyc;
      ST_WPULSE:            return wp_cyc;
      default:              return 1;
    endcase
  endfunction

  // Strobe levels that belong to each state.
  function automatic sac_strobe_t sac_decode(input sac_state_e st, input bit oe_high);
    sac_strobe_t s;
    s = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
    case (st)
      ST_RSETUP: s.cs_n = 1'b0;
      ST_RACC:   begin s.cs_n = 1'b0; s.oe_n = 1'b0; end
      ST_WSETUP: begin s.cs_n = 1'b0; s.oe_n = oe_high ? 1'b1 : 1'b0; end
      ST_WTURN:  begin s.cs_n = 1'b0; s.we_n = 1'b0; s.oe_n = oe_high ? 1'b1 : 1'b0; end
      ST_WPULSE: begin s.cs_n = 1'b0; s.we_n = 1'b0; s.oe_n = oe_high ? 1'b1 : 1'b0;
                       s.drv = 1'b1; end
      ST_WREL:   s.drv = 1'b1;
      default:   ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sac_phase_timer.sv
module sac_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sac_strobe_reg.sv
module sac_strobe_reg
  import sac_pkg::*;
#(
  parameter bit WR_OE_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sac_state_e next_st,
  output logic       cs_n,
  output logic       we_n,
  output logic       oe_n,
  output logic       drv_en
);
  sac_strobe_t nxt_s;
  sac_strobe_t cur_s;

  always_comb nxt_s = sac_decode(next_st, WR_OE_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_s <= '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
    else        cur_s <= nxt_s;
  end

  assign cs_n   = cur_s.cs_n;
  assign we_n   = cur_s.we_n;
  assign oe_n   = cur_s.oe_n;
  assign drv_en = cur_s.drv;
endmodule

// File: rtl/sac_read_capture.sv
module sac_read_capture #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_data <= dq_in;
    end
  end
endmodule

// File: rtl/sac_async_sram_ctrl.sv
module sac_async_sram_ctrl
  import sac_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 4,
  parameter int SETUP_CYC    = 1,
  parameter int RD_CYC       = 1,
  parameter int TURN_CYC     = 1,
  parameter int WP_OE_HI_CYC = 1,
  parameter int WP_OE_LO_CYC = 1,
  parameter bit WR_OE_HIGH   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int WP_CYC  = sac_wp_cycles(WR_OE_HIGH, WP_OE_HI_CYC, WP_OE_LO_CYC);
  localparam int MAX_A   = (SETUP_CYC > RD_CYC) ? SETUP_CYC : RD_CYC;
  localparam int MAX_B   = (TURN_CYC > WP_CYC) ? TURN_CYC : WP_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  sac_state_e        state, next_st;
  logic              accept;
  logic              phase_done;
  logic              capture;
  logic              timer_load;
  logic [CNT_W-1:0]  timer_val;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = (state == ST_RACC) && phase_done;

  always_comb begin
    next_st = state;
    case (state)
      ST_IDLE:   if (accept) next_st = req_write ? ST_WSETUP : ST_RSETUP;
      ST_RSETUP: if (phase_done) next_st = ST_RACC;
      ST_RACC:   if (phase_done) next_st = ST_IDLE;
      ST_WSETUP: if (phase_done) next_st = ST_WTURN;
      ST_WTURN:  if (phase_done) next_st = ST_WPULSE;
      ST_WPULSE: if (phase_done) next_st = ST_WREL;
      ST_WREL:   next_st = ST_IDLE;
      default:   next_st = ST_IDLE;
    endcase
  end

  assign timer_load = (next_st != state);
  assign timer_val  = CNT_W'(sac_phase_cycles(next_st, SETUP_CYC, RD_CYC,
                                              TURN_CYC, WP_CYC) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= next_st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      wdata_q  <= req_wdata;
    end
  end

  assign mem_dq_out = wdata_q;

  sac_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .done     (phase_done)
  );

  sac_strobe_reg #(.WR_OE_HIGH(WR_OE_HIGH)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .next_st (next_st),
    .cs_n    (mem_cs_n),
    .we_n    (mem_we_n),
    .oe_n    (mem_oe_n),
    .drv_en  (mem_dq_oe)
  );

  sac_read_capture #(.DATA_W(DATA_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .dq_in     (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_rdata)
  );
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              accept,
  input logic              capture,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_ready_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n);

  p_capture_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_dq_oe));

  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_drive_after_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_cs_n && !mem_oe_n && mem_we_n));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && mem_dq_oe) |=> !mem_dq_oe);

  p_we_needs_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
endmodule

bind sac_async_sram_ctrl sac_checker #(.ADDR_W(ADDR_W)) u_sac_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .accept    (accept),
  .capture   (capture),
  .rsp_valid (rsp_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/test_sac_async_sram_ctrl.sv
module test_sac_async_sram_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  AW = 18;
  localparam int  DW = 4;
  localparam int  SET_C = 1;
  localparam int  RD_C  = 1;
  localparam int  TRN_C = 1;
  localparam int  WPH_C = 1;
  localparam int  WPL_C = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // index 0: output enable held high in writes; index 1: left low
  logic          req_valid [2];
  logic          req_ready [2];
  logic          req_write [2];
  logic [AW-1:0] req_addr  [2];
  logic [DW-1:0] req_wdata [2];
  logic          rsp_valid [2];
  logic [DW-1:0] rsp_rdata [2];
  logic [AW-1:0] mem_addr  [2];
  logic          cs_n [2], we_n [2], oe_n [2], dq_oe [2];
  logic [DW-1:0] dq_out [2];
  logic [DW-1:0] dq_in  [2];
  logic [DW-1:0] mem0 [256];
  logic [DW-1:0] mem1 [256];

  int n_chk = 0;
  int n_bad = 0;
  int n_contention = 0;

  sac_async_sram_ctrl #(.SETUP_CYC(SET_C), .RD_CYC(RD_C), .TURN_CYC(TRN_C),
    .WP_OE_HI_CYC(WPH_C), .WP_OE_LO_CYC(WPL_C), .WR_OE_HIGH(1'b1)) i_sac_async_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
    .req_write(req_write[0]), .req_addr(req_addr[0]), .req_wdata(req_wdata[0]),
    .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]), .mem_addr(mem_addr[0]),
    .mem_cs_n(cs_n[0]), .mem_we_n(we_n[0]), .mem_oe_n(oe_n[0]),
    .mem_dq_out(dq_out[0]), .mem_dq_oe(dq_oe[0]), .mem_dq_in(dq_in[0]));

  sac_async_sram_ctrl #(.SETUP_CYC(SET_C), .RD_CYC(RD_C), .TURN_CYC(TRN_C),
    .WP_OE_HI_CYC(WPH_C), .WP_OE_LO_CYC(WPL_C), .WR_OE_HIGH(1'b0)) i_sac_async_sram_ctrl_oelow (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
    .req_write(req_write[1]), .req_addr(req_addr[1]), .req_wdata(req_wdata[1]),
    .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]), .mem_addr(mem_addr[1]),
    .mem_cs_n(cs_n[1]), .mem_we_n(we_n[1]), .mem_oe_n(oe_n[1]),
    .mem_dq_out(dq_out[1]), .mem_dq_oe(dq_oe[1]), .mem_dq_in(dq_in[1]));

  // Behavioural memory: drives in read state, stores on every write cycle with data.
  assign dq_in[0] = (!cs_n[0] && !oe_n[0] && we_n[0]) ? mem0[mem_addr[0][7:0]] : '0;
  assign dq_in[1] = (!cs_n[1] && !oe_n[1] && we_n[1]) ? mem1[mem_addr[1][7:0]] : '0;

  always @(posedge clk) begin
    if (!cs_n[0] && !we_n[0] && dq_oe[0]) mem0[mem_addr[0][7:0]] <= dq_out[0];
    if (!cs_n[1] && !we_n[1] && dq_oe[1]) mem1[mem_addr[1][7:0]] <= dq_out[1];
  end

  always @(negedge clk) begin
    for (int k = 0; k < 2; k++)
      if (rst_n && dq_oe[k] && !cs_n[k] && !oe_n[k] && we_n[k]) n_contention++;
  end

  function automatic int exp_wp(input int idx);
    return (idx == 0) ? WPH_C : WPL_C;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < 2; k++) begin
      check(cs_n[k] && we_n[k] && oe_n[k], "R1 strobes high", {cs_n[k], we_n[k], oe_n[k]}, 3'b111);
      check(!dq_oe[k] && req_ready[k] && !rsp_valid[k], "R1 idle outputs",
            {dq_oe[k], req_ready[k], rsp_valid[k]}, 3'b010);
    end
  endtask

  task automatic t_read(input int idx, input logic [AW-1:0] a, input logic [DW-1:0] exp_d);
    int n_setup = 0, n_acc = 0, lat = 0;
    bit bad_we = 0, addr_bad = 0, got = 0;
    @(negedge clk);
    req_valid[idx] = 1'b1; req_write[idx] = 1'b0; req_addr[idx] = a;
    @(negedge clk);
    req_valid[idx] = 1'b0;
    req_addr[idx] = ~a;   // R9: must not reach the memory
    lat = 1;
    check(!req_ready[idx], "R2 ready low during access", req_ready[idx], 0);
    for (int c = 0; c < 20 && !got; c++) begin
      if (rsp_valid[idx]) begin
        got = 1;
        check(lat == SET_C + RD_C + 1, "R4 response latency", lat, SET_C + RD_C + 1);
        check(rsp_rdata[idx] == exp_d, "R4 read data", rsp_rdata[idx], exp_d);
        check(req_ready[idx], "R2 ready back in idle", req_ready[idx], 1);
      end else begin
        if (!cs_n[idx] && oe_n[idx]) n_setup++;
        if (!cs_n[idx] && !oe_n[idx]) n_acc++;
        if (!cs_n[idx] && (!we_n[idx] || dq_oe[idx])) bad_we = 1;
        if (!cs_n[idx] && mem_addr[idx] != a) addr_bad = 1;
        @(negedge clk);
        lat++;
      end
    end
    check(got, "R4 response seen", got, 1);
    check(n_setup == SET_C, "R3 setup cycles", n_setup, SET_C);
    check(n_acc == RD_C, "R3 access cycles", n_acc, RD_C);
    check(!bad_we, "R3 no write strobe or drive in read", bad_we, 0);
    check(!addr_bad, "R9 address taken at acceptance", addr_bad, 0);
    @(negedge clk);
    check(!rsp_valid[idx], "R4 valid lasts one cycle", rsp_valid[idx], 0);
  endtask

  task automatic t_write(input int idx, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n_pre = 0, n_we = 0, n_drv = 0, n_rel = 0;
    bit drv_early = 0, data_bad = 0, oe_bad = 0, cs_bad = 0, addr_bad = 0, prev_we_low = 0;
    bit done = 0;
    @(negedge clk);
    req_valid[idx] = 1'b1; req_write[idx] = 1'b1; req_addr[idx] = a; req_wdata[idx] = d;
    @(negedge clk);
    req_valid[idx] = 1'b0;
    req_wdata[idx] = ~d;  // R9
    req_addr[idx] = ~a;
    for (int c = 0; c < 20 && !done; c++) begin
      if (req_ready[idx] && cs_n[idx] && !dq_oe[idx]) done = 1;
      else begin
        if (!cs_n[idx] && we_n[idx] && !prev_we_low) n_pre++;
        if (!we_n[idx]) begin
          n_we++;
          if (cs_n[idx]) cs_bad = 1;
          if (idx == 0 && !oe_n[idx]) oe_bad = 1;
          if (idx == 1 && oe_n[idx]) oe_bad = 1;
          if (dq_oe[idx]) begin
            n_drv++;
            if (n_we <= TRN_C) drv_early = 1;
            if (dq_out[idx] != d) data_bad = 1;
          end
        end else if (dq_oe[idx]) n_rel++;
        if (idx == 0 && !cs_n[idx] && !oe_n[idx]) oe_bad = 1;
        if (!cs_n[idx] && mem_addr[idx] != a) addr_bad = 1;
        prev_we_low = !we_n[idx];
        @(negedge clk);
      end
    end
    check(done, "R2 write completes to idle", done, 1);
    check(n_pre == SET_C, "R5 setup before write strobe", n_pre, SET_C);
    check(n_we == TRN_C + exp_wp(idx), "R5 write strobe length", n_we, TRN_C + exp_wp(idx));
    check(n_drv == exp_wp(idx), "R5 driven cycles", n_drv, exp_wp(idx));
    check(!drv_early, "R5 no drive in turnaround", drv_early, 0);
    check(n_rel == 1, "R6 release one cycle after strobe", n_rel, 1);
    check(!cs_bad, "R7 write strobe only when selected", cs_bad, 0);
    check(!oe_bad, "R8 output enable per mode", oe_bad, 0);
    check(!data_bad && !addr_bad, "R9 data and address taken at acceptance",
          {data_bad, addr_bad}, 0);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      req_valid[k] = 0; req_write[k] = 0; req_addr[k] = '0; req_wdata[k] = '0;
    end
    for (int i = 0; i < 256; i++) begin
      mem0[i] = DW'(i * 3); mem1[i] = DW'(i * 5 + 1);
    end
    #(CLK_PERIOD * 2.3);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(0, 18'h00012, DW'(8'h12 * 3));
    t_read(1, 18'h3FF07, DW'(8'h07 * 5 + 1));
    t_write(0, 18'h00040, 4'hA);
    t_read(0, 18'h00040, 4'hA);
    t_write(1, 18'h25581, 4'h5);
    t_read(1, 18'h25581, 4'h5);
    t_write(0, 18'h3FFFF, 4'hF);
    t_write(0, 18'h000FF, 4'h0);
    t_read(0, 18'h3FFFF, 4'h0);   // shares the model's low address bits with 0x000FF
    t_write(1, 18'h00000, 4'h9);
    t_read(1, 18'h00000, 4'h9);
    check(n_contention == 0, "R6 no bus contention", n_contention, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule